// File: doc/BRIEF.md
# FIFO DMA Request Signalling

This block produces the two active-low request pins that tell an external DMA engine when one UART channel needs service. It does not hold the FIFOs. It watches the occupancy counts of the receive and transmit FIFOs, the two trigger levels, a one-cycle receive time-out pulse, and a single mode bit. From these it decides the level of each pin.

The mode bit is bit 3 of the FIFO control register. When it is clear, each pin is a plain decode of its FIFO: empty or not empty. When it is set, each pin becomes a latch with hysteresis. The receive pin asserts low once enough data has arrived, either at the trigger level or on a time-out, and it releases only when the FIFO has been drained to empty. The transmit pin goes high once the FIFO is full, and it returns low only when the fill level falls below the transmit trigger.

Both pins are registered, so each one reflects its inputs one clock later. A trigger input outside the legal range 1 to DEPTH is clamped into that range.

Top module: `fifo_dma_ready`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `rx_req_n` is 1 and `tx_req_n` is 0, whatever the other inputs are.
- R2: With `dma_mode` = 0, `rx_req_n` one cycle later is 1 if `rx_count` was 0 and 0 otherwise. `rx_timeout` has no effect.
- R3: With `dma_mode` = 0, `tx_req_n` one cycle later is 0 if `tx_count` was 0 and 1 otherwise.
- R4: With `dma_mode` = 1, `rx_count` = 0 sets `rx_req_n` to 1 in the next cycle. This takes priority over a time-out in the same cycle.
- R5: With `dma_mode` = 1, `rx_count` >= effective receive trigger clears `rx_req_n` to 0 in the next cycle.
- R6: With `dma_mode` = 1, `rx_timeout` = 1 with `rx_count` != 0 clears `rx_req_n` to 0 in the next cycle.
- R7: With `dma_mode` = 1, when `rx_count` is between 1 and trigger-1 and there is no time-out, `rx_req_n` keeps its value.
- R8: With `dma_mode` = 1, `tx_count` = DEPTH sets `tx_req_n` to 1 in the next cycle.
- R9: With `dma_mode` = 1, `tx_count` < effective transmit trigger clears `tx_req_n` to 0 in the next cycle.
- R10: With `dma_mode` = 1, when `tx_count` is between the trigger and DEPTH-1, `tx_req_n` keeps its value.
- R11: A change of `dma_mode` takes effect in the next cycle under the new mode's rule. When DMA mode is entered with the count in a hold band, the pin keeps the level it had under the non-DMA rule.
- R12: A trigger value of 0 acts as 1, and a value above DEPTH acts as DEPTH. This applies to both triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_mode | input | 1 | DMA mode select (FIFO control bit 3) |
| rx_count | input | CW | Receive FIFO occupancy, 0..DEPTH |
| rx_trig | input | CW | Receive trigger level |
| rx_timeout | input | 1 | One-cycle receive time-out pulse |
| tx_count | input | CW | Transmit FIFO occupancy, 0..DEPTH |
| tx_trig | input | CW | Transmit trigger level |
| rx_req_n | output | 1 | Receive request pin, active low |
| tx_req_n | output | 1 | Transmit request pin, active low |

## Verification
The bench instantiates the block with its default DEPTH of 32. That makes CW six bits wide, so the count inputs can present both an empty and a completely full FIFO, and trigger values at the top of the range (32) can be tested directly. The extra headroom in the trigger inputs also lets the bench drive 0 and values from 33 to 63, which exercises the clamping of R12. The counts are driven directly rather than through a FIFO, so the hysteresis bands and mode switches can be visited in any order.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
  typedef enum logic [1:0] {
    EV_HOLD  = 2'd0,
    EV_SET   = 2'd1,
    EV_CLEAR = 2'd2
  } ev_e;
endpackage

// File: rtl/fdr_trig_clamp.sv
module fdr_trig_clamp #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] trig_raw,
  output logic [CW-1:0] trig_eff
);
  localparam logic [CW-1:0] TOP = CW'(DEPTH);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_comb begin
    if (trig_raw == '0)      trig_eff = ONE;
    else if (trig_raw > TOP) trig_eff = TOP;
    else                     trig_eff = trig_raw;
  end
endmodule

// File: rtl/fdr_event.sv
module fdr_event
  import fdr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter bit IS_TX = 1'b0
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] trig,
  input  logic          force_clear,
  output ev_e           ev,
  output logic          level
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  generate
    if (IS_TX) begin : g_tx
      // set when full, clear when below trigger; the two are exclusive after clamping
      always_comb begin
        level = (count != '0);
        if (count == FULL)                      ev = EV_SET;
        else if ((count < trig) || force_clear) ev = EV_CLEAR;
        else                                    ev = EV_HOLD;
      end
    end else begin : g_rx
      // empty releases the request; trigger or time-out asserts it
      always_comb begin
        level = (count == '0);
        if (count == '0)                         ev = EV_SET;
        else if ((count >= trig) || force_clear) ev = EV_CLEAR;
        else                                     ev = EV_HOLD;
      end
    end
  endgenerate
endmodule

// File: rtl/fdr_pin.sv
module fdr_pin
  import fdr_pkg::*;
#(
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic dma,
  input  ev_e  ev,
  input  logic level,
  output logic pin_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= RST_VAL;
    end else if (!dma) begin
      pin_q <= level;
    end else begin
      unique case (ev)
        EV_SET:   pin_q <= 1'b1;
        EV_CLEAR: pin_q <= 1'b0;
        default:  pin_q <= pin_q;
      endcase
    end
  end
endmodule

// File: rtl/fifo_dma_ready.sv
module fifo_dma_ready
  import fdr_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dma_mode,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] rx_trig,
  input  logic          rx_timeout,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] tx_trig,
  output logic          rx_req_n,
  output logic          tx_req_n
);
  logic [CW-1:0] rx_trig_eff, tx_trig_eff;
  ev_e           rx_ev, tx_ev;
  logic          rx_lvl, tx_lvl;

  fdr_trig_clamp #(.DEPTH(DEPTH), .CW(CW)) u_rx_clamp (
    .trig_raw(rx_trig), .trig_eff(rx_trig_eff)
  );
  fdr_trig_clamp #(.DEPTH(DEPTH), .CW(CW)) u_tx_clamp (
    .trig_raw(tx_trig), .trig_eff(tx_trig_eff)
  );

  fdr_event #(.DEPTH(DEPTH), .CW(CW), .IS_TX(1'b0)) u_rx_ev (
    .count(rx_count), .trig(rx_trig_eff), .force_clear(rx_timeout),
    .ev(rx_ev), .level(rx_lvl)
  );
  fdr_event #(.DEPTH(DEPTH), .CW(CW), .IS_TX(1'b1)) u_tx_ev (
    .count(tx_count), .trig(tx_trig_eff), .force_clear(1'b0),
    .ev(tx_ev), .level(tx_lvl)
  );

  fdr_pin #(.RST_VAL(1'b1)) u_rx_pin (
    .clk(clk), .rst(rst), .dma(dma_mode), .ev(rx_ev), .level(rx_lvl),
    .pin_q(rx_req_n)
  );
  fdr_pin #(.RST_VAL(1'b0)) u_tx_pin (
    .clk(clk), .rst(rst), .dma(dma_mode), .ev(tx_ev), .level(tx_lvl),
    .pin_q(tx_req_n)
  );
endmodule

// File: rtl/fifo_dma_ready_chk.sv
module fifo_dma_ready_chk #(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          dma_mode,
  input logic [CW-1:0] rx_count,
  input logic [CW-1:0] rx_trig,
  input logic          rx_timeout,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] tx_trig,
  input logic          rx_req_n,
  input logic          tx_req_n
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (rx_req_n && !tx_req_n)); // R1

  AST_RX_PLAIN: assert property (@(posedge clk) disable iff (rst)
    !dma_mode |=> (rx_req_n == ($past(rx_count) == '0))); // R2

  AST_TX_PLAIN: assert property (@(posedge clk) disable iff (rst)
    !dma_mode |=> (tx_req_n == ($past(tx_count) != '0))); // R3

  AST_RX_EMPTY_SET: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && rx_count == '0) |=> rx_req_n); // R4

  AST_RX_TRIG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && rx_trig != '0 && rx_count != '0 && rx_count >= rx_trig)
      |=> !rx_req_n); // R5

  AST_RX_TIMEOUT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && rx_timeout && rx_count != '0) |=> !rx_req_n); // R6

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && !rx_timeout && rx_count != '0 && rx_trig <= FULL && rx_count < rx_trig)
      |=> $stable(rx_req_n)); // R7

  AST_TX_FULL_SET: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && tx_count == FULL) |=> tx_req_n); // R8

  AST_TX_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && tx_trig <= FULL && tx_count < tx_trig) |=> !tx_req_n); // R9

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dma_mode && tx_trig != '0 && tx_count >= tx_trig && tx_count < FULL)
      |=> $stable(tx_req_n)); // R10
endmodule

bind fifo_dma_ready fifo_dma_ready_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .dma_mode(dma_mode), .rx_count(rx_count),
  .rx_trig(rx_trig), .rx_timeout(rx_timeout), .tx_count(tx_count),
  .tx_trig(tx_trig), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
);

// File: tb/fifo_dma_ready_bench.sv
module fifo_dma_ready_bench;
  localparam int CLK_P = 10;
  localparam int DEPTH = 32;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dma_mode = 1'b0;
  logic [CW-1:0] rx_count = '0, rx_trig = CW'(8), tx_count = '0, tx_trig = CW'(16);
  logic          rx_timeout = 1'b0;
  logic          rx_req_n, tx_req_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fifo_dma_ready #(.DEPTH(DEPTH)) u_fifo_dma_ready (
    .clk(clk), .rst(rst), .dma_mode(dma_mode), .rx_count(rx_count),
    .rx_trig(rx_trig), .rx_timeout(rx_timeout), .tx_count(tx_count),
    .tx_trig(tx_trig), .rx_req_n(rx_req_n), .tx_req_n(tx_req_n)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rx_step(input logic [CW-1:0] c, input logic to, input logic exp, input string req);
    rx_count = c; rx_timeout = to;
    tick();
    chk(req, rx_req_n, exp);
    rx_timeout = 1'b0;
  endtask

  task automatic tx_step(input logic [CW-1:0] c, input logic exp, input string req);
    tx_count = c;
    tick();
    chk(req, tx_req_n, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; dma_mode = 1'b0; rx_count = CW'(5); tx_count = CW'(5);
    tick(); tick();
    chk("R1 rx during reset", rx_req_n, 1'b1);
    chk("R1 tx during reset", tx_req_n, 1'b0);
    rx_count = '0; tx_count = '0;
    rst = 1'b0;
    tick();
    chk("R1 rx after reset", rx_req_n, 1'b1);
    chk("R1 tx after reset", tx_req_n, 1'b0);
  endtask

  task automatic t_plain();
    dma_mode = 1'b0;
    rx_step(CW'(1), 1'b0, 1'b0, "R2 rx one byte");
    rx_step(CW'(32), 1'b0, 1'b0, "R2 rx full");
    rx_step(CW'(0), 1'b0, 1'b1, "R2 rx empty");
    rx_step(CW'(0), 1'b1, 1'b1, "R2 timeout ignored when empty");
    rx_step(CW'(3), 1'b1, 1'b0, "R2 timeout ignored with data");
    tx_step(CW'(1), 1'b1, "R3 tx one byte");
    tx_step(CW'(32), 1'b1, "R3 tx full");
    tx_step(CW'(0), 1'b0, "R3 tx empty");
  endtask

  task automatic t_dma_rx();
    dma_mode = 1'b1; rx_trig = CW'(8);
    rx_step(CW'(0), 1'b0, 1'b1, "R4 rx empty sets");
    rx_step(CW'(3), 1'b0, 1'b1, "R7 rx band holds high");
    rx_step(CW'(7), 1'b0, 1'b1, "R7 rx trig-1 holds high");
    rx_step(CW'(8), 1'b0, 1'b0, "R5 rx at trigger clears");
    rx_step(CW'(3), 1'b0, 1'b0, "R7 rx band holds low");
    rx_step(CW'(0), 1'b0, 1'b1, "R4 rx drained sets");
    rx_step(CW'(2), 1'b1, 1'b0, "R6 rx timeout clears");
    rx_step(CW'(2), 1'b0, 1'b0, "R7 rx holds after timeout");
    rx_step(CW'(0), 1'b1, 1'b1, "R4 empty wins over timeout");
    rx_trig = CW'(32);
    rx_step(CW'(31), 1'b0, 1'b1, "R7 rx trig 32 holds at 31");
    rx_step(CW'(32), 1'b0, 1'b0, "R5 rx trig 32 clears at full");
    rx_step(CW'(0), 1'b0, 1'b1, "R4 rx empty after full");
  endtask

  task automatic t_dma_tx();
    dma_mode = 1'b1; tx_trig = CW'(16);
    tx_step(CW'(5), 1'b0, "R9 tx below trigger low");
    tx_step(CW'(32), 1'b1, "R8 tx full sets");
    tx_step(CW'(20), 1'b1, "R10 tx band holds high");
    tx_step(CW'(16), 1'b1, "R10 tx at trigger holds high");
    tx_step(CW'(15), 1'b0, "R9 tx below trigger clears");
    tx_step(CW'(31), 1'b0, "R10 tx band holds low");
    tx_step(CW'(32), 1'b1, "R8 tx full sets again");
  endtask

  task automatic t_mode();
    dma_mode = 1'b1; rx_trig = CW'(8); tx_trig = CW'(16);
    rx_step(CW'(10), 1'b0, 1'b0, "R5 rx setup clear");
    rx_count = CW'(3); dma_mode = 1'b0;
    tick(); chk("R11 rx to plain mode with data", rx_req_n, 1'b0);
    rx_count = '0;
    tick(); chk("R11 rx plain empty", rx_req_n, 1'b1);
    rx_count = CW'(3); dma_mode = 1'b1;
    tick(); chk("R11 rx enter DMA in band holds", rx_req_n, 1'b1);
    dma_mode = 1'b0;
    tick(); chk("R11 rx back to plain", rx_req_n, 1'b0);
    dma_mode = 1'b1;
    tick(); chk("R11 rx enter DMA holds low", rx_req_n, 1'b0);
    tx_step(CW'(32), 1'b1, "R8 tx setup set");
    tx_count = '0; dma_mode = 1'b0;
    tick(); chk("R11 tx to plain empty", tx_req_n, 1'b0);
    tx_count = CW'(20); dma_mode = 1'b1;
    tick(); chk("R11 tx enter DMA in band holds", tx_req_n, 1'b0);
    dma_mode = 1'b0;
    tick(); chk("R11 tx plain with data", tx_req_n, 1'b1);
    dma_mode = 1'b1;
    tick(); chk("R11 tx enter DMA holds high", tx_req_n, 1'b1);
  endtask

  task automatic t_clamp();
    dma_mode = 1'b1;
    rx_trig = '0;
    rx_step(CW'(0), 1'b0, 1'b1, "R12 rx trig0 empty");
    rx_step(CW'(1), 1'b0, 1'b0, "R12 rx trig0 acts as 1");
    rx_trig = CW'(40);
    rx_step(CW'(0), 1'b0, 1'b1, "R12 rx trig40 empty");
    rx_step(CW'(31), 1'b0, 1'b1, "R12 rx trig40 holds at 31");
    rx_step(CW'(32), 1'b0, 1'b0, "R12 rx trig40 acts as 32");
    tx_trig = '0;
    tx_step(CW'(32), 1'b1, "R12 tx trig0 full");
    tx_step(CW'(1), 1'b1, "R12 tx trig0 holds at 1");
    tx_step(CW'(0), 1'b0, "R12 tx trig0 acts as 1");
    tx_trig = CW'(63);
    tx_step(CW'(32), 1'b1, "R12 tx trig63 full sets");
    tx_step(CW'(31), 1'b0, "R12 tx trig63 acts as 32");
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_plain();
    t_dma_rx();
    t_dma_tx();
    t_mode();
    t_clamp();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule